// File: doc/BRIEF.md
# Serial ROM Block Read Host

This block is the master side of a three-wire serial link to a byte-organised serial read-only memory. A client gives it a 20-bit start address, a byte count and a one-cycle start strobe. The block lowers chip select and shifts out a 72-bit request: the read opcode, the address split across four bytes in the memory's scattered layout, and four dummy bytes. It then keeps the serial clock running and collects one byte for each requested position.

Each collected byte appears on a data output with a one-cycle valid pulse. When the last byte is in, the block raises chip select and holds it high for a fixed number of system cycles. It then pulses done. The serial clock half-period is a run-time divider counted in system-clock cycles. The block drives the serial clock itself and never outputs a clock edge while chip select is high.

Top module: `srom_reader`

## Requirements
- R1: A transfer starts with chip select going low while the serial clock is low. The first eight bits on the serial output are the read opcode 0x52, most significant bit first.
- R2: The next four request bytes carry the address as follows. Address bits 19..17 go in bits 2..0 of request byte 1. Bits 16..9 fill request byte 2. Bits 8..7 go in bits 1..0 of request byte 3. Bits 6..0 go in bits 6..0 of request byte 4. Every byte is sent MSB first.
- R3: Every unused bit in request bytes 1, 3 and 4 is sent as 0. Request bytes 5 to 8 are sent as 0x00.
- R4: The serial clock rests low and changes only while chip select is low. Each of its high and low phases lasts `half_div` system cycles, and a value of 0 counts as 1. The serial output changes only on falling serial-clock edges.
- R5: After the 72 request bits, the serial input is sampled on each falling edge and packed MSB first. Exactly `byte_count` bytes are delivered, each with a one-cycle `rd_valid` pulse, while chip select is still low.
- R6: Chip select rises after the last byte. It then stays high for `CS_GAP_CYC` system cycles, after which `done` is high for exactly one cycle.
- R7: A start with `byte_count` equal to 0 raises `done` in the next cycle. Chip select and the serial clock do not move.
- R8: `busy` is high from the cycle after an accepted start through the `done` cycle, and low right after it. A start seen while `busy` is high is ignored and does not disturb the transfer in progress.
- R9: Under reset, chip select is high and the serial clock, serial output, `busy`, `done` and `rd_valid` are low.
- R10: The first rising serial-clock edge comes one half-period after chip select falls. Chip select rises one half-period after the last falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request strobe |
| start_addr | input | 20 | First byte address to fetch |
| byte_count | input | CNT_W | Number of bytes to fetch |
| half_div | input | DIV_W | Serial clock half-period in system cycles (0 treated as 1) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rd_valid | output | 1 | One-cycle pulse for each delivered byte |
| rd_data | output | 8 | Delivered byte |
| cs_n | output | 1 | Active-low chip select to the memory |
| sclk | output | 1 | Serial clock to the memory |
| mosi | output | 1 | Serial data to the memory |
| miso | input | 1 | Serial data from the memory |

## Verification
The assertions expect `half_div` and the other request inputs to matter only in the cycle a start is accepted. The checker therefore latches the divider at that point and measures every serial-clock phase and the chip-select tail against it. They also expect a byte to take at least sixteen system cycles, so that valid pulses never touch. The bench drives requests only on falling system-clock edges, with divider values 0 to 3 and counts up to twelve. It changes inputs during a transfer only in the deliberate ignored-start case. A behavioural memory model answers on the serial lines from the request header it actually received.

// File: rtl/srom_pkg.sv
package srom_pkg;
  localparam int ADDR_W   = 20;
  localparam int HDR_BITS = 72;
  localparam logic [7:0] OP_READ = 8'h52;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_SHIFT, ST_TAIL, ST_GAP, ST_FIN
  } st_e;

  // Scatter the linear address into the memory's request layout.
  function automatic logic [HDR_BITS-1:0] build_header(input logic [ADDR_W-1:0] a);
    logic [7:0] hi, mid, lo, ba;
    hi  = {5'b0, a[19:17]};
    mid = a[16:9];
    lo  = {6'b0, a[8:7]};
    ba  = {1'b0, a[6:0]};
    return {OP_READ, hi, mid, lo, ba, 32'h0};
  endfunction

  // Total serial bits of one request plus its data phase, minus one.
  function automatic int last_bit_index(input int nbytes);
    return HDR_BITS + 8 * nbytes - 1;
  endfunction
endpackage

// File: rtl/srom_tick.sv
module srom_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  always_comb lim = (half == '0) ? '0 : half - 1'b1;

  assign tick = run && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/srom_txrx.sv
module srom_txrx
  import srom_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [HDR_BITS-1:0] hdr,
  input  logic                shift,
  input  logic                capture,
  input  logic                byte_end,
  input  logic                miso,
  output logic                mosi,
  output logic                rd_valid,
  output logic [7:0]          rd_data
);
  logic [HDR_BITS-1:0] tx_sr;
  logic [7:0]          rx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tx_sr <= '0;
    else if (load)  tx_sr <= hdr;
    else if (shift) tx_sr <= {tx_sr[HDR_BITS-2:0], 1'b0};
  end

  assign mosi = tx_sr[HDR_BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sr    <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= capture && byte_end;
      if (capture) rx_sr <= {rx_sr[6:0], miso};
      if (capture && byte_end) rd_data <= {rx_sr[6:0], miso};
    end
  end
endmodule

// File: rtl/srom_ctrl.sv
module srom_ctrl
  import srom_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int DIV_W      = 8,
  parameter int CS_GAP_CYC = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] byte_count,
  input  logic [DIV_W-1:0] half_div,
  input  logic             tick,
  output logic             run,
  output logic [DIV_W-1:0] half_q,
  output logic             load,
  output logic             fall_evt,
  output logic             capture,
  output logic             byte_end,
  output logic             cs_n,
  output logic             sclk,
  output logic             busy,
  output logic             done
);
  localparam int MAX_BITS = HDR_BITS + 8 * ((1 << CNT_W) - 1);
  localparam int BIT_W    = $clog2(MAX_BITS + 1);
  localparam int GAP_W    = $clog2(CS_GAP_CYC + 1);

  st_e              state;
  logic             sclk_q;
  logic [BIT_W-1:0] bitcnt;
  logic [BIT_W-1:0] last_bit;
  logic [GAP_W-1:0] gcnt;
  logic             last_fall;

  assign run       = (state == ST_LEAD) || (state == ST_SHIFT) || (state == ST_TAIL);
  assign fall_evt  = (state == ST_SHIFT) && tick && sclk_q;
  assign capture   = fall_evt && (bitcnt >= BIT_W'(HDR_BITS));
  assign byte_end  = (bitcnt[2:0] == 3'b111);
  assign last_fall = fall_evt && (bitcnt == last_bit);
  assign load      = (state == ST_IDLE) && start && (byte_count != '0);
  assign cs_n      = !run;
  assign sclk      = sclk_q;
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      sclk_q   <= 1'b0;
      bitcnt   <= '0;
      last_bit <= '0;
      gcnt     <= '0;
      half_q   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          half_q <= half_div;
          if (byte_count == '0) begin
            state <= ST_FIN;
          end else begin
            bitcnt   <= '0;
            last_bit <= BIT_W'(last_bit_index(int'(byte_count)));
            state    <= ST_LEAD;
          end
        end
        ST_LEAD: if (tick) begin
          sclk_q <= 1'b1;
          state  <= ST_SHIFT;
        end
        ST_SHIFT: if (tick) begin
          if (sclk_q) begin
            sclk_q <= 1'b0;
            bitcnt <= bitcnt + 1'b1;
            if (last_fall) state <= ST_TAIL;
          end else begin
            sclk_q <= 1'b1;
          end
        end
        ST_TAIL: if (tick) begin
          gcnt  <= '0;
          state <= ST_GAP;
        end
        ST_GAP: begin
          if (gcnt == GAP_W'(CS_GAP_CYC - 1)) state <= ST_FIN;
          else gcnt <= gcnt + 1'b1;
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/srom_reader.sv
module srom_reader
  import srom_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int DIV_W      = 8,
  parameter int CS_GAP_CYC = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [19:0]      start_addr,
  input  logic [CNT_W-1:0] byte_count,
  input  logic [DIV_W-1:0] half_div,
  output logic             busy,
  output logic             done,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             cs_n,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso
);
  logic             tick;
  logic             run;
  logic [DIV_W-1:0] half_q;
  logic             load;
  logic             sclk_fall;
  logic             capture;
  logic             byte_end;
  logic             byte_cap;

  assign byte_cap = capture && byte_end;

  srom_ctrl #(.CNT_W(CNT_W), .DIV_W(DIV_W), .CS_GAP_CYC(CS_GAP_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
    .half_div(half_div), .tick(tick), .run(run), .half_q(half_q),
    .load(load), .fall_evt(sclk_fall), .capture(capture), .byte_end(byte_end),
    .cs_n(cs_n), .sclk(sclk), .busy(busy), .done(done)
  );

  srom_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .half(half_q), .tick(tick)
  );

  srom_txrx u_txrx (
    .clk(clk), .rst_n(rst_n), .load(load), .hdr(build_header(start_addr)),
    .shift(sclk_fall), .capture(capture), .byte_end(byte_end), .miso(miso),
    .mosi(mosi), .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: rtl/srom_reader_chk.sv
module srom_reader_chk #(
  parameter int DIV_W      = 8,
  parameter int CS_GAP_CYC = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [DIV_W-1:0] half_div,
  input logic             cs_n,
  input logic             sclk,
  input logic             mosi,
  input logic             busy,
  input logic             done,
  input logic             rd_valid,
  input logic             byte_cap
);
  localparam int RL_W  = DIV_W + 1;
  localparam int GAP_W = $clog2(CS_GAP_CYC + 1);

  logic [DIV_W-1:0] eff;
  logic [RL_W-1:0]  run_len;
  logic [GAP_W-1:0] hi_cnt;
  logic             sclk_d, cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff     <= DIV_W'(1);
      run_len <= '0;
      hi_cnt  <= GAP_W'(CS_GAP_CYC);
      sclk_d  <= 1'b0;
      cs_d    <= 1'b1;
    end else begin
      sclk_d <= sclk;
      cs_d   <= cs_n;
      if (start && !busy) eff <= (half_div == '0) ? DIV_W'(1) : half_div;
      if ((sclk != sclk_d) || (cs_n != cs_d)) run_len <= RL_W'(1);
      else if (run_len != '1) run_len <= run_len + 1'b1;
      if (!cs_n) hi_cnt <= '0;
      else if (hi_cnt != GAP_W'(CS_GAP_CYC)) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  assert_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  assert_mosi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));
  assert_half_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk != sclk_d) |-> (run_len == RL_W'(eff)));
  assert_tail_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !cs_d) |-> (run_len == RL_W'(eff)));
  assert_lead_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && cs_d) |-> !sclk);
  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  assert_valid_in_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !cs_n);
  assert_byte_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_cap |=> rd_valid);
  assert_done_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && busy));
  assert_cs_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && cs_d) |-> (hi_cnt >= GAP_W'(CS_GAP_CYC)));
  assert_done_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

bind srom_reader srom_reader_chk #(.DIV_W(DIV_W), .CS_GAP_CYC(CS_GAP_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .half_div(half_div), .cs_n(cs_n),
  .sclk(sclk), .mosi(mosi), .busy(busy), .done(done), .rd_valid(rd_valid),
  .byte_cap(byte_cap)
);

// File: tb/sim_srom_reader.sv
module sim_srom_reader;
  localparam int GAP = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [19:0] start_addr = '0;
  logic [7:0]  byte_count = '0;
  logic [7:0]  half_div = 8'd1;
  logic        busy, done, rd_valid, cs_n, sclk, mosi;
  logic [7:0]  rd_data;
  logic        miso = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  srom_reader #(.CNT_W(8), .DIV_W(8), .CS_GAP_CYC(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .byte_count(byte_count), .half_div(half_div), .busy(busy), .done(done),
    .rd_valid(rd_valid), .rd_data(rd_data), .cs_n(cs_n), .sclk(sclk),
    .mosi(mosi), .miso(miso)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] rom_byte(input logic [19:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ {a[19:16], 4'hA};
  endfunction

  // Expected request image, built bit by bit from the field map.
  function automatic logic [71:0] exp_header(input logic [19:0] a);
    logic [71:0] h;
    h = '0;
    h[71:64] = 8'h52;
    for (int i = 0; i < 20; i++) begin
      int p;
      if (i <= 6)       p = 32 + i;
      else if (i <= 8)  p = 40 + (i - 7);
      else if (i <= 16) p = 48 + (i - 9);
      else              p = 56 + (i - 17);
      h[p] = a[i];
    end
    return h;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Memory model.
  logic [71:0] m_hdr;
  logic [19:0] m_addr;
  int          m_rises;
  int          cs_falls = 0;
  bit          spacing_bad;
  int          exp_space;
  time         t_csfall, t_first, t_prev_rise, t_lastfall, t_csrise;

  always @(negedge cs_n) begin
    m_rises = 0; m_hdr = '0; spacing_bad = 0; t_csfall = $time; cs_falls++;
  end
  always @(posedge cs_n) begin t_csrise = $time; miso <= 1'b0; end
  always @(negedge sclk) t_lastfall = $time;
  always @(posedge sclk) if (!cs_n) begin
    if (m_rises == 0) t_first = $time;
    else if ($time - t_prev_rise != exp_space) spacing_bad = 1;
    t_prev_rise = $time;
    if (m_rises < 72) begin
      m_hdr = {m_hdr[70:0], mosi};
    end else begin
      int j;
      logic [7:0] b;
      if (m_rises == 72) m_addr = {m_hdr[58:56], m_hdr[55:48], m_hdr[41:40], m_hdr[38:32]};
      j = m_rises - 72;
      b = rom_byte(m_addr + 20'(j / 8));
      miso <= b[7 - (j % 8)];
    end
    m_rises++;
  end

  // Output monitor.
  logic [7:0] got [0:255];
  int         n_got;
  int         n_done;
  time        t_done;
  always @(negedge clk) begin
    if (rd_valid) begin got[n_got] = rd_data; n_got++; end
    if (done) begin n_done++; t_done = $time - 4; end
  end

  task automatic run_xfer(input logic [19:0] a, input int cnt, input int h, input bit poke);
    int heff, cyc, falls0;
    logic [71:0] eh;
    heff = (h == 0) ? 1 : h;
    exp_space = 16 * heff;
    n_got = 0; n_done = 0; falls0 = cs_falls;
    @(negedge clk);
    start_addr = a; byte_count = 8'(cnt); half_div = 8'(h); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R8 busy after start", busy, 1);
    cyc = 0;
    while (n_done == 0 && cyc < 20000) begin
      if (poke && cyc == 40) begin
        start_addr = ~a; byte_count = 8'd3; half_div = 8'd2; start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(n_done == 1, "R6 done seen (watchdog)", n_done, 1);
    chk(cs_n == 1'b1, "R6 cs high at done", cs_n, 1);
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R8 idle after done", {busy, done}, 0);
    if (cnt == 0) begin
      chk(cs_falls == falls0, "R7 no cs activity", cs_falls - falls0, 0);
      chk(n_got == 0, "R7 no bytes", n_got, 0);
      return;
    end
    chk(cs_falls == falls0 + 1, "R8 single cs frame", cs_falls - falls0, 1);
    eh = exp_header(a);
    chk(m_hdr[71:64] == 8'h52, "R1 opcode", m_hdr[71:64], 8'h52);
    chk(m_hdr[63:32] == eh[63:32], "R2 address bytes", m_hdr[63:32], eh[63:32]);
    chk(m_hdr[31:0] == 32'h0, "R3 dummy bytes", m_hdr[31:0], 0);
    chk(m_rises == 72 + 8 * cnt, "R4 clock count", m_rises, 72 + 8 * cnt);
    chk(!spacing_bad, "R4 rise spacing", spacing_bad, 0);
    chk((t_first - t_csfall) == 8 * heff, "R10 lead", (t_first - t_csfall) / 8, heff);
    chk((t_csrise - t_lastfall) == 8 * heff, "R10 tail", (t_csrise - t_lastfall) / 8, heff);
    chk((t_done - t_csrise) == 8 * GAP, "R6 gap", (t_done - t_csrise) / 8, GAP);
    chk(n_got == cnt, "R5 byte count", n_got, cnt);
    for (int i = 0; i < cnt && i < n_got; i++) begin
      logic [7:0] e;
      e = rom_byte(a + 20'(i));
      chk(got[i] == e, "R5 data byte", got[i], e);
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(cs_n == 1 && sclk == 0 && mosi == 0, "R9 reset lines", {cs_n, sclk, mosi}, 3'b100);
    chk(busy == 0 && done == 0 && rd_valid == 0, "R9 reset flags", {busy, done, rd_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 1 && sclk == 0 && busy == 0, "R9 after release", {cs_n, sclk, busy}, 3'b100);
    // Directed corners.
    run_xfer(20'hFFFFF, 3, 1, 0);          // all address bits set
    run_xfer(20'h00000, 1, 0, 0);          // divider 0 acts as 1
    run_xfer(20'h5A5A5, 0, 2, 0);          // zero count
    run_xfer(20'hAAAAA, 4, 2, 1);          // start ignored mid-transfer
    run_xfer(20'hFFFFE, 5, 3, 0);          // address crossing the top
    // Random transfers.
    for (int k = 0; k < 10; k++) begin
      logic [19:0] a;
      a = 20'($urandom);
      run_xfer(a, 1 + int'($urandom % 12), int'($urandom % 4), 0);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule